// File: doc/BRIEF.md
# Masked Ternary Logic Unit

This block evaluates an arbitrary Boolean function of three inputs on every bit position of a 256-bit vector. The function is named by an 8-bit truth-table code. Each output bit is the code bit that a 3-bit index selects. The index is formed from the same-position bits of operands a, b and c, with a as the most significant index bit.

After the function stage, an 8-bit lane mask chooses which lanes keep the computed value. The lane width is either 32 or 64 bits. Three masking policies are available:

- none: every lane keeps the function result and the mask plays no part.
- merge: a lane whose mask bit is clear shows operand a. There is no separate source input for merging.
- zero: a lane whose mask bit is clear is forced to zero.

The result leaves the block through one register stage by default. A parameter can remove that stage.

Top module: `ternlog_unit`

## Requirements
- R1: With masking policy none, result bit i equals func_i[{opa_i[i], opb_i[i], opc_i[i]}], for every function code and every bit position.
- R2: Function code 8'h00 gives an all-zero result and code 8'hFF gives an all-ones result, whatever the operands are.
- R3: Code 8'h01 gives NOR of the three operands and code 8'hFE gives their OR. Code 8'hF0 reproduces opa_i, 8'hCC reproduces opb_i and 8'hAA reproduces opc_i.
- R4: mask_mode_i = 2'b00 selects policy none. With this policy lane_mask_i has no effect on the result.
- R5: mask_mode_i = 2'b01 selects merge. A lane whose mask bit is clear takes the bits of opa_i in that lane. A lane whose mask bit is set takes the function result.
- R6: mask_mode_i = 2'b10 selects zero. A lane whose mask bit is clear is all zero. The encoding 2'b11 behaves exactly as 2'b10.
- R7: With wide_lane_i = 0, mask bit j governs bits [32j+31:32j], for j = 0 to 7. With wide_lane_i = 1, mask bit j governs bits [64j+63:64j], for j = 0 to 3, and lane_mask_i[7:4] has no effect.
- R8: With the default parameters, the result appears on result_o at the rising edge that samples the inputs, so it is one cycle later. While rst is high at a rising edge, result_o is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opa_i | input | 256 | Operand a, most significant truth-table index bit; merge source |
| opb_i | input | 256 | Operand b, middle index bit |
| opc_i | input | 256 | Operand c, least significant index bit |
| func_i | input | 8 | Truth-table function code |
| lane_mask_i | input | 8 | One bit per lane |
| wide_lane_i | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| mask_mode_i | input | 2 | 00 none, 01 merge, 10 or 11 zero |
| result_o | output | 256 | Registered result |

## Verification
Every one of the 256 function codes is driven with fresh random operands and a random mask. This is repeated under each masking policy and each lane width, so that a wrong index order or a wrong truth-table bit shows up as a mismatch.

Directed codes check that the design reproduces each operand in turn and produces the two constants. These tell apart a swapped index ordering from a correct one.

Masks of all-clear, all-set and alternating lanes separate merge from zero. The same bench also shows the 32-bit and 64-bit lane mappings producing different results.

A wide-lane pair differs only in the upper mask nibble, which shows that those bits are ignored. The reserved mode encoding is checked against the zero policy.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

  localparam int unsigned FN_W = 8;

  typedef enum logic [1:0] {
    MM_NONE     = 2'd0,
    MM_MERGE    = 2'd1,
    MM_ZERO     = 2'd2,
    MM_ZERO_ALT = 2'd3
  } mask_mode_e;

  typedef enum logic {
    LANE_NARROW = 1'b0,
    LANE_WIDE   = 1'b1
  } lane_size_e;

  // One bit of a three-input truth table; x is the top index bit.
  function automatic logic lut3(input logic [FN_W-1:0] fn,
                                input logic x, input logic y, input logic z);
    return fn[{x, y, z}];
  endfunction

endpackage

// File: rtl/tlu_bitfn.sv
module tlu_bitfn
  import tlu_pkg::*;
#(
  parameter int unsigned VEC_W = 256
) (
  input  logic [VEC_W-1:0] x_i,
  input  logic [VEC_W-1:0] y_i,
  input  logic [VEC_W-1:0] z_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic [VEC_W-1:0] f_o
);

  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    assign f_o[i] = lut3(fn_i, x_i[i], y_i[i], z_i[i]);
  end

endmodule

// File: rtl/tlu_lane_mask.sv
module tlu_lane_mask
  import tlu_pkg::*;
#(
  parameter int unsigned VEC_W    = 256,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned MASK_W   = 8
) (
  input  logic [MASK_W-1:0]          mask_i,
  input  lane_size_e                 size_i,
  output logic [VEC_W/NARROW_W-1:0]  chunk_en_o
);

  localparam int unsigned NCHUNK = VEC_W / NARROW_W;

  // Each narrow chunk finds its governing mask bit: its own index for
  // narrow lanes, half of it for wide lanes (two chunks per lane).
  for (genvar q = 0; q < NCHUNK; q++) begin : g_chunk
    logic nar_en;
    logic wid_en;
    if (q < MASK_W) begin : g_nar
      assign nar_en = mask_i[q];
    end else begin : g_nar_none
      assign nar_en = 1'b0;
    end
    if ((q / 2) < MASK_W) begin : g_wid
      assign wid_en = mask_i[q/2];
    end else begin : g_wid_none
      assign wid_en = 1'b0;
    end
    assign chunk_en_o[q] = (size_i == LANE_WIDE) ? wid_en : nar_en;
  end

  // R7
  wide_pairs_chk: assert final (size_i != LANE_WIDE || NCHUNK < 2 ||
                                chunk_en_o[0] == chunk_en_o[1]);

endmodule

// File: rtl/tlu_merge.sv
module tlu_merge
  import tlu_pkg::*;
#(
  parameter int unsigned VEC_W    = 256,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [VEC_W-1:0]          fres_i,
  input  logic [VEC_W-1:0]          keep_src_i,
  input  logic [VEC_W/NARROW_W-1:0] chunk_en_i,
  input  mask_mode_e                mode_i,
  output logic [VEC_W-1:0]          y_o
);

  localparam int unsigned NCHUNK = VEC_W / NARROW_W;

  logic unmasked;
  logic merging;

  assign unmasked = (mode_i == MM_NONE);
  assign merging  = (mode_i == MM_MERGE);

  for (genvar q = 0; q < NCHUNK; q++) begin : g_chunk
    logic take_fn;
    assign take_fn = unmasked | chunk_en_i[q];
    assign y_o[q*NARROW_W +: NARROW_W] =
      take_fn ? fres_i[q*NARROW_W +: NARROW_W] :
      merging ? keep_src_i[q*NARROW_W +: NARROW_W] :
                {NARROW_W{1'b0}};
  end

endmodule

// File: rtl/ternlog_unit.sv
module ternlog_unit
  import tlu_pkg::*;
#(
  parameter int unsigned VEC_W    = 256,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned MASK_W   = 8,
  parameter bit          OUT_REG  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VEC_W-1:0]  opa_i,
  input  logic [VEC_W-1:0]  opb_i,
  input  logic [VEC_W-1:0]  opc_i,
  input  logic [FN_W-1:0]   func_i,
  input  logic [MASK_W-1:0] lane_mask_i,
  input  logic              wide_lane_i,
  input  logic [1:0]        mask_mode_i,
  output logic [VEC_W-1:0]  result_o
);

  localparam int unsigned NCHUNK = VEC_W / NARROW_W;

  mask_mode_e         mode_e;
  lane_size_e         size_e;
  logic [VEC_W-1:0]   fres;
  logic [NCHUNK-1:0]  chunk_en;
  logic [VEC_W-1:0]   nxt;

  assign mode_e = mask_mode_e'(mask_mode_i);
  assign size_e = lane_size_e'(wide_lane_i);

  tlu_bitfn #(.VEC_W(VEC_W)) u_bitfn (
    .x_i  (opa_i),
    .y_i  (opb_i),
    .z_i  (opc_i),
    .fn_i (func_i),
    .f_o  (fres)
  );

  tlu_lane_mask #(.VEC_W(VEC_W), .NARROW_W(NARROW_W), .MASK_W(MASK_W)) u_lane_mask (
    .mask_i     (lane_mask_i),
    .size_i     (size_e),
    .chunk_en_o (chunk_en)
  );

  tlu_merge #(.VEC_W(VEC_W), .NARROW_W(NARROW_W)) u_merge (
    .fres_i     (fres),
    .keep_src_i (opa_i),
    .chunk_en_i (chunk_en),
    .mode_i     (mode_e),
    .y_o        (nxt)
  );

  if (OUT_REG) begin : g_reg
    logic [VEC_W-1:0] res_q;
    logic             live_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        res_q  <= '0;
        live_q <= 1'b0;
      end else begin
        res_q  <= nxt;
        live_q <= 1'b1;
      end
    end

    assign result_o = res_q;

    // R2
    const_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(func_i) == 8'h00 && $past(mask_mode_i) == 2'b00)
        |-> (result_o == '0));

    // R2
    const_one_chk: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(func_i) == 8'hFF && $past(mask_mode_i) == 2'b00)
        |-> (result_o == '1));

    // R3
    pass_a_chk: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(func_i) == 8'hF0 && $past(mask_mode_i) == 2'b00)
        |-> (result_o == $past(opa_i)));

    // R5
    merge_all_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(mask_mode_i) == 2'b01 && $past(lane_mask_i) == '0)
        |-> (result_o == $past(opa_i)));

    // R6
    zero_all_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(mask_mode_i[1]) && $past(lane_mask_i) == '0)
        |-> (result_o == '0));

    // R7
    wide_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(wide_lane_i) && $past(mask_mode_i[1]) &&
       $past(lane_mask_i[MASK_W/2-1:0]) == '0)
        |-> (result_o == '0));
  end else begin : g_comb
    assign result_o = nxt;
  end

endmodule

// File: tb/test_ternlog_unit.sv
module test_ternlog_unit;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [VW-1:0] opa, opb, opc;
  logic [7:0]    func;
  logic [7:0]    lmask;
  logic          wide;
  logic [1:0]    mode;
  logic [VW-1:0] result;

  int errors = 0;
  int checks = 0;

  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ternlog_unit i_ternlog_unit (
    .clk         (clk),
    .rst         (rst),
    .opa_i       (opa),
    .opb_i       (opb),
    .opc_i       (opc),
    .func_i      (func),
    .lane_mask_i (lmask),
    .wide_lane_i (wide),
    .mask_mode_i (mode),
    .result_o    (result)
  );

  function automatic logic [VW-1:0] rnd256();
    logic [VW-1:0] v;
    for (int w = 0; w < VW/32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  // Reference taken from the requirements (R1, R5, R6, R7).
  function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b,
                                          logic [VW-1:0] c, logic [7:0] fn,
                                          logic [7:0] k, logic wd, logic [1:0] md);
    logic [VW-1:0] r;
    for (int i = 0; i < VW; i++) begin
      logic t;
      int   lane;
      t    = fn[{a[i], b[i], c[i]}];
      lane = wd ? i / 64 : i / 32;
      case (md)
        2'b00:   r[i] = t;
        2'b01:   r[i] = k[lane] ? t : a[i];
        default: r[i] = k[lane] ? t : 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic drive(logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] c,
                       logic [7:0] fn, logic [7:0] k, logic wd, logic [1:0] md,
                       logic [VW-1:0] expv, string tag);
    @(negedge clk);
    opa = a; opb = b; opc = c; func = fn; lmask = k; wide = wd; mode = md;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  task automatic drive_m(logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] c,
                         logic [7:0] fn, logic [7:0] k, logic wd, logic [1:0] md,
                         string tag);
    drive(a, b, c, fn, k, wd, md, model(a, b, c, fn, k, wd, md), tag);
  endtask

  // Monitor: one cycle latency (R8), pop just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic [VW-1:0] e;
        string         t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (result !== e) begin
          errors++;
          $display("FAIL %s got=%h exp=%h", t, result, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog R8 got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [VW-1:0] a, b, c;
    opa = '1; opb = '1; opc = '1; func = 8'hFF; lmask = 8'hFF; wide = 1'b0; mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== '0) begin
      errors++;
      $display("FAIL R8 reset got=%h exp=%h", result, {VW{1'b0}});
    end
    rst = 1'b0;

    a = rnd256(); b = rnd256(); c = rnd256();
    // R2 constants
    drive(a, b, c, 8'h00, 8'h00, 1'b0, 2'b00, '0, "R2 code00");
    drive(a, b, c, 8'hFF, 8'h00, 1'b0, 2'b00, '1, "R2 codeFF");
    // R3 named functions
    drive(a, b, c, 8'h01, 8'h00, 1'b0, 2'b00, ~(a | b | c), "R3 nor");
    drive(a, b, c, 8'hFE, 8'h00, 1'b0, 2'b00, a | b | c, "R3 or");
    drive(a, b, c, 8'hF0, 8'h00, 1'b0, 2'b00, a, "R3 pass_a");
    drive(a, b, c, 8'hCC, 8'h00, 1'b0, 2'b00, b, "R3 pass_b");
    drive(a, b, c, 8'hAA, 8'h00, 1'b0, 2'b00, c, "R3 pass_c");
    // R4 mask ignored in none mode
    drive(a, b, c, 8'h96, 8'h00, 1'b1, 2'b00, a ^ b ^ c, "R4 mask0");
    drive(a, b, c, 8'h96, 8'h5A, 1'b0, 2'b00, a ^ b ^ c, "R4 mask5A");
    // R5 merge extremes
    drive(a, b, c, 8'h80, 8'h00, 1'b0, 2'b01, a, "R5 merge clear");
    drive(a, b, c, 8'h80, 8'hFF, 1'b0, 2'b01, a & b & c, "R5 merge set");
    // R6 zero and reserved encoding
    drive(a, b, c, 8'hFF, 8'h00, 1'b0, 2'b10, '0, "R6 zero clear");
    drive_m(a, b, c, 8'hE8, 8'h55, 1'b0, 2'b10, "R6 zero alt");
    drive_m(a, b, c, 8'hE8, 8'h55, 1'b0, 2'b11, "R6 code11");
    drive(a, b, c, 8'hFF, 8'hA5, 1'b0, 2'b11,
          {{32{1'b1}}, 32'h0, {32{1'b1}}, 32'h0, 32'h0, {32{1'b1}}, 32'h0, {32{1'b1}}},
          "R6 code11 lanes");
    // R7 lane mapping: same mask, two widths
    drive(a, b, c, 8'hFF, 8'h05, 1'b0, 2'b10, {192'h0, {32{1'b1}}, 32'h0, {32{1'b1}}},
          "R7 narrow map");
    drive(a, b, c, 8'hFF, 8'h05, 1'b1, 2'b10, {64'h0, {64{1'b1}}, 64'h0, {64{1'b1}}},
          "R7 wide map");
    drive(a, b, c, 8'hFF, 8'hF5, 1'b1, 2'b10, {64'h0, {64{1'b1}}, 64'h0, {64{1'b1}}},
          "R7 wide upper ignored");
    drive_m(a, b, c, 8'h3C, 8'hF0, 1'b1, 2'b01, "R7 wide merge upper");

    // R1 R4 R5 R6 R7 full code sweep
    for (int md = 0; md < 3; md++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int fn = 0; fn < 256; fn++) begin
          string tg;
          tg = (md == 0) ? "R1 R4 sweep" : (md == 1) ? "R5 R7 sweep" : "R6 R7 sweep";
          drive_m(rnd256(), rnd256(), rnd256(), fn[7:0], 8'($urandom),
                  wd[0], md[1:0], tg);
        end
      end
    end

    repeat (3) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule